// File: doc/BRIEF.md
# Register-Tagged Line Association Buffer

This block keeps the binding between architectural register numbers and the eight 256-bit data lines of a small load/store buffer. It holds no line data. It tracks which register slots point at which line, and whether each line's data has arrived. A register is found by comparing its number against every slot tag at the same time. The matching slot names its line directly, with no mapping table in between. The decoder uses the ready flag of the bound line to hold an instruction at decode until its data is present.

There are eight tag slots, one per line. Slot i may bind only to line i-1, line i or line i+1, so a line can be shared by at most three neighbouring slots. The slots at the two edges have only two legal targets. Because of this narrow neighbourhood, a flush of one line can find every slot bound to it and release all of them in one cycle. A bind that names register 0 is a preload: it binds no slot. Every result is registered and appears one cycle after the request.

Top module: `reg_line_assoc`

## Requirements
- R1: After reset every slot is unbound and every line is not ready, so any lookup misses with ready low. The release mask is zero and the error pulse is low.
- R2: A legal bind of slot i with select 2'b00, 2'b01 or 2'b10 binds the slot to line i-1, i or i+1 respectively. A lookup of that register one cycle later reports a hit and that line index.
- R3: A bind is rejected when any of these holds: the select is 2'b11, slot 0 asks for select 2'b00, or slot 7 asks for select 2'b10. A rejected bind raises bind_err for exactly the following cycle and leaves all bindings unchanged. A legal bind leaves bind_err low.
- R4: When several valid slots hold the same register number, the lookup reports the line of the lowest-numbered matching slot.
- R5: A fill marks its line ready. A hitting lookup reports the ready flag of the bound line. A lookup that misses reports ready low and line 0.
- R6: A flush clears its line's ready flag and unbinds every slot bound to that line. One cycle later it reports a release mask with bit i set for each slot i that was released. The mask is zero in any cycle not following a flush.
- R7: A bind naming register 0 changes no slot and raises no error. A lookup of register 0 never hits.
- R8: Slots i-1, i and i+1 can all bind to line i at once. Each of them then looks up to line i, and one flush of line i releases all three.
- R9: A fill and a flush of the same line in the same cycle leave that line not ready. A new bind of an already bound slot replaces its earlier binding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bind_valid | input | 1 | Bind request strobe |
| bind_slot | input | 3 | Slot to bind |
| bind_reg | input | 6 | Register number to bind (0 = preload, no binding) |
| bind_sel | input | 2 | Neighbour select: 00 line below, 01 same line, 10 line above, 11 illegal |
| lookup_valid | input | 1 | Lookup request strobe |
| lookup_reg | input | 6 | Register number to look up |
| fill_valid | input | 1 | Line-ready strobe |
| fill_line | input | 3 | Line whose data has arrived |
| flush_valid | input | 1 | Flush strobe |
| flush_line | input | 3 | Line to flush |
| look_hit | output | 1 | Registered lookup hit |
| look_line | output | 3 | Registered line index of the hit |
| look_ready | output | 1 | Registered ready flag of the bound line |
| release_mask | output | 8 | Slots released by the previous cycle's flush |
| bind_err | output | 1 | Pulse for a rejected bind |

## Verification
All results are due one clock edge after the request. Lookup outputs, the release mask and the error pulse are registered at the same edge that updates the bindings. A lookup therefore sees the state as it was before that edge. A lookup issued in the cycle after a bind, fill or flush sees that change. The bench applies each request at a falling edge and samples one time unit after the next rising edge. It issues any dependent lookup only in a later cycle, so each check reads exactly the edge its result belongs to.

// File: rtl/rla_pkg.sv
// Shared definitions for the register-tagged line association buffer.
// Assumes one tag slot per line; the neighbour select encoding is fixed.
package rla_pkg;
    typedef enum logic [1:0] {
        SEL_BELOW = 2'b00,
        SEL_SAME  = 2'b01,
        SEL_ABOVE = 2'b10,
        SEL_BAD   = 2'b11
    } nbr_sel_t;
endpackage

// File: rtl/rla_slot.sv
// One register tag slot: holds valid, register tag and neighbour select,
// and derives the absolute line it points at. Assumes the caller only
// raises bind_we for legal, non-zero-register binds.
module rla_slot #(
    parameter int SLOT_ID   = 0,
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 6,
    localparam int LIDX_W   = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bind_we,
    input  logic [TAG_W-1:0]  bind_reg,
    input  logic [1:0]        bind_sel,
    input  logic              flush_valid,
    input  logic [LIDX_W-1:0] flush_line,
    output logic              valid_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [LIDX_W-1:0] line_o,
    output logic              flush_hit_o
);
    import rla_pkg::*;

    logic             valid_q;
    logic [TAG_W-1:0] tag_q;
    nbr_sel_t         sel_q;

    // Translate the relative select into an absolute line index.
    always_comb begin
        unique case (sel_q)
            SEL_BELOW: line_o = LIDX_W'(SLOT_ID - 1);
            SEL_ABOVE: line_o = LIDX_W'(SLOT_ID + 1);
            default:   line_o = LIDX_W'(SLOT_ID);
        endcase
    end

    // Flag this slot as bound to the line being flushed.
    assign flush_hit_o = valid_q && (line_o == flush_line);

    // Bind overwrites the slot; otherwise a matching flush unbinds it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            sel_q   <= SEL_SAME;
        end else if (bind_we) begin
            valid_q <= 1'b1;
            tag_q   <= bind_reg;
            sel_q   <= nbr_sel_t'(bind_sel);
        end else if (flush_valid && flush_hit_o) begin
            valid_q <= 1'b0;
        end
    end

    assign valid_o = valid_q;
    assign tag_o   = tag_q;

    // R6: a flushed slot that is not rebound is unbound afterwards.
    assert_flush_unbinds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && flush_hit_o && !bind_we) |=> !valid_q);

    // R9: a bind always leaves the slot valid with the new tag.
    assert_bind_overwrites_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bind_we |=> (valid_q && tag_q == $past(bind_reg)));
endmodule

// File: rtl/rla_ready_bank.sv
// Per-line ready flags: a fill sets a line, a flush clears it, and the
// flush wins when both name the same line in one cycle.
module rla_ready_bank #(
    parameter int NUM_LINES = 8,
    localparam int LIDX_W   = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fill_valid,
    input  logic [LIDX_W-1:0]    fill_line,
    input  logic                 flush_valid,
    input  logic [LIDX_W-1:0]    flush_line,
    output logic [NUM_LINES-1:0] ready_o
);
    logic [NUM_LINES-1:0] ready_q;

    // One flip-flop per line, flush taking priority over fill.
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ready_q[l] <= 1'b0;
            end else if (flush_valid && flush_line == LIDX_W'(l)) begin
                ready_q[l] <= 1'b0;
            end else if (fill_valid && fill_line == LIDX_W'(l)) begin
                ready_q[l] <= 1'b1;
            end
        end
    end

    assign ready_o = ready_q;

    // R5: a fill without a colliding flush leaves its line ready.
    assert_fill_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !(flush_valid && flush_line == fill_line))
        |=> ready_q[$past(fill_line)]);

    // R9: a flush leaves its line not ready even with a same-line fill.
    assert_flush_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> !ready_q[$past(flush_line)]);
endmodule

// File: rtl/rla_match.sv
// Parallel tag compare across all slots with lowest-slot priority.
// Purely combinational; assumes tags of invalid slots are ignored.
module rla_match #(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 6,
    localparam int LIDX_W   = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]             valid_i,
    input  logic [NUM_LINES-1:0][TAG_W-1:0]  tag_i,
    input  logic [NUM_LINES-1:0][LIDX_W-1:0] line_i,
    input  logic [TAG_W-1:0]                 key_i,
    output logic                             hit_o,
    output logic [LIDX_W-1:0]                line_o
);
    logic [NUM_LINES-1:0] match;

    // Compare the key with every slot at once.
    for (genvar s = 0; s < NUM_LINES; s++) begin : g_cmp
        assign match[s] = valid_i[s] && (tag_i[s] == key_i);
    end

    // Pick the lowest matching slot by scanning from the top down.
    always_comb begin
        hit_o  = 1'b0;
        line_o = '0;
        for (int s = NUM_LINES - 1; s >= 0; s--) begin
            if (match[s]) begin
                hit_o  = 1'b1;
                line_o = line_i[s];
            end
        end
    end
endmodule

// File: rtl/reg_line_assoc.sv
// Register-tagged line association buffer top. Checks bind legality,
// hosts the slots, the ready bank and the matcher, and registers all
// results so each is due one cycle after its request.
module reg_line_assoc #(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 6,
    localparam int LIDX_W   = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bind_valid,
    input  logic [LIDX_W-1:0]    bind_slot,
    input  logic [TAG_W-1:0]     bind_reg,
    input  logic [1:0]           bind_sel,
    input  logic                 lookup_valid,
    input  logic [TAG_W-1:0]     lookup_reg,
    input  logic                 fill_valid,
    input  logic [LIDX_W-1:0]    fill_line,
    input  logic                 flush_valid,
    input  logic [LIDX_W-1:0]    flush_line,
    output logic                 look_hit,
    output logic [LIDX_W-1:0]    look_line,
    output logic                 look_ready,
    output logic [NUM_LINES-1:0] release_mask,
    output logic                 bind_err
);
    import rla_pkg::*;

    logic                             bind_bad;
    logic                             bind_ok;
    logic [NUM_LINES-1:0]             slot_valid;
    logic [NUM_LINES-1:0][TAG_W-1:0]  slot_tag;
    logic [NUM_LINES-1:0][LIDX_W-1:0] slot_line;
    logic [NUM_LINES-1:0]             slot_flush_hit;
    logic [NUM_LINES-1:0]             line_ready;
    logic                             m_hit;
    logic [LIDX_W-1:0]                m_line;

    // Reject the illegal select and the out-of-range edge neighbours.
    always_comb begin
        bind_bad = (nbr_sel_t'(bind_sel) == SEL_BAD)
                || (nbr_sel_t'(bind_sel) == SEL_BELOW && bind_slot == '0)
                || (nbr_sel_t'(bind_sel) == SEL_ABOVE && bind_slot == LIDX_W'(NUM_LINES - 1));
    end

    // A legal bind naming register 0 is a preload and writes no slot.
    assign bind_ok = bind_valid && !bind_bad && (bind_reg != '0);

    for (genvar s = 0; s < NUM_LINES; s++) begin : g_slot
        rla_slot #(
            .SLOT_ID   (s),
            .NUM_LINES (NUM_LINES),
            .TAG_W     (TAG_W)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .bind_we     (bind_ok && bind_slot == LIDX_W'(s)),
            .bind_reg    (bind_reg),
            .bind_sel    (bind_sel),
            .flush_valid (flush_valid),
            .flush_line  (flush_line),
            .valid_o     (slot_valid[s]),
            .tag_o       (slot_tag[s]),
            .line_o      (slot_line[s]),
            .flush_hit_o (slot_flush_hit[s])
        );
    end

    rla_ready_bank #(.NUM_LINES(NUM_LINES)) u_ready (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_valid  (fill_valid),
        .fill_line   (fill_line),
        .flush_valid (flush_valid),
        .flush_line  (flush_line),
        .ready_o     (line_ready)
    );

    rla_match #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_match (
        .valid_i (slot_valid),
        .tag_i   (slot_tag),
        .line_i  (slot_line),
        .key_i   (lookup_reg),
        .hit_o   (m_hit),
        .line_o  (m_line)
    );

    // Register lookup results, release mask and bind error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            look_hit     <= 1'b0;
            look_line    <= '0;
            look_ready   <= 1'b0;
            release_mask <= '0;
            bind_err     <= 1'b0;
        end else begin
            look_hit     <= lookup_valid && m_hit;
            look_line    <= (lookup_valid && m_hit) ? m_line : '0;
            look_ready   <= lookup_valid && m_hit && line_ready[m_line];
            release_mask <= flush_valid ? slot_flush_hit : '0;
            bind_err     <= bind_valid && bind_bad;
        end
    end

    // R3: an illegal bind is answered by the error pulse.
    assert_bad_bind_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bind_valid && bind_sel == 2'b11) |=> bind_err);

    // R6: no release is reported without a flush the cycle before.
    assert_mask_needs_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_valid |=> (release_mask == '0));

    // R7: register 0 is never found by a lookup.
    assert_reg0_never_hits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && lookup_reg == '0) |=> !look_hit);

    // R5: a miss never reports ready.
    assert_miss_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !look_hit |-> !look_ready);
endmodule

// File: tb/reg_line_assoc_bench.sv
module reg_line_assoc_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bind_valid = 1'b0;
    logic [2:0] bind_slot = '0;
    logic [5:0] bind_reg = '0;
    logic [1:0] bind_sel = '0;
    logic       lookup_valid = 1'b0;
    logic [5:0] lookup_reg = '0;
    logic       fill_valid = 1'b0;
    logic [2:0] fill_line = '0;
    logic       flush_valid = 1'b0;
    logic [2:0] flush_line = '0;
    logic       look_hit;
    logic [2:0] look_line;
    logic       look_ready;
    logic [7:0] release_mask;
    logic       bind_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_line_assoc u_reg_line_assoc (
        .clk (clk), .rst_n (rst_n),
        .bind_valid (bind_valid), .bind_slot (bind_slot),
        .bind_reg (bind_reg), .bind_sel (bind_sel),
        .lookup_valid (lookup_valid), .lookup_reg (lookup_reg),
        .fill_valid (fill_valid), .fill_line (fill_line),
        .flush_valid (flush_valid), .flush_line (flush_line),
        .look_hit (look_hit), .look_line (look_line), .look_ready (look_ready),
        .release_mask (release_mask), .bind_err (bind_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one request cycle at a falling edge; sample just after the rising edge.
    task automatic cyc(input logic bv, input int bs, input int br, input int bsl,
                       input logic lv, input int lr,
                       input logic fv, input int fl,
                       input logic xv, input int xl);
        @(negedge clk);
        bind_valid = bv; bind_slot = 3'(bs); bind_reg = 6'(br); bind_sel = 2'(bsl);
        lookup_valid = lv; lookup_reg = 6'(lr);
        fill_valid = fv; fill_line = 3'(fl);
        flush_valid = xv; flush_line = 3'(xl);
        @(posedge clk);
        #1;
        @(negedge clk);
        bind_valid = 0; lookup_valid = 0; fill_valid = 0; flush_valid = 0;
        #1;
    endtask

    task automatic do_bind(input int s, input int r, input int sel);
        cyc(1, s, r, sel, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic do_look(input int r);
        cyc(0, 0, 0, 0, 1, r, 0, 0, 0, 0);
    endtask
    task automatic do_fill(input int l);
        cyc(0, 0, 0, 0, 0, 0, 1, l, 0, 0);
    endtask
    task automatic do_flush(input int l);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, l);
    endtask

    // Note: cyc samples within the request's next cycle, so outputs read right
    // after a task call belong to that request. Read them before the next call.

    task automatic clear_all();
        for (int l = 0; l < 8; l++) do_flush(l);
    endtask

    task automatic t_reset();
        check("R1 mask after reset", int'(release_mask), 0);
        check("R1 err after reset", int'(bind_err), 0);
        do_look(5);
        check("R1 lookup misses", int'(look_hit), 0);
        check("R1 ready low", int'(look_ready), 0);
    endtask

    task automatic t_mapping();
        for (int s = 0; s < 8; s++) begin
            for (int sel = 0; sel < 3; sel++) begin
                if (!((s == 0 && sel == 0) || (s == 7 && sel == 2))) begin
                    do_bind(s, 10 + s, sel);
                    check("R3 legal bind no err", int'(bind_err), 0);
                    do_look(10 + s);
                    check("R2 hit", int'(look_hit), 1);
                    check("R2 line", int'(look_line), s + sel - 1);
                end
            end
        end
        do_bind(4, 44, 0);
        do_bind(4, 45, 2);
        do_look(44);
        check("R9 old binding replaced", int'(look_hit), 0);
        do_look(45);
        check("R9 new binding line", int'(look_line), 5);
        clear_all();
    endtask

    task automatic t_illegal();
        do_bind(0, 40, 0);
        check("R3 slot0 below err", int'(bind_err), 1);
        do_look(40);
        check("R3 slot0 below not bound", int'(look_hit), 0);
        check("R3 err one cycle only", int'(bind_err), 0);
        do_bind(7, 41, 2);
        check("R3 slot7 above err", int'(bind_err), 1);
        do_look(41);
        check("R3 slot7 above not bound", int'(look_hit), 0);
        do_bind(3, 42, 1);
        do_bind(3, 43, 3);
        check("R3 select 11 err", int'(bind_err), 1);
        do_look(42);
        check("R3 prior binding kept", int'(look_hit), 1);
        check("R3 prior binding line", int'(look_line), 3);
        clear_all();
    endtask

    task automatic t_priority_ready();
        do_bind(2, 20, 1);
        do_bind(5, 20, 2);
        do_look(20);
        check("R4 lowest slot wins", int'(look_line), 2);
        check("R5 unfilled not ready", int'(look_ready), 0);
        do_fill(6);
        do_look(20);
        check("R4 still slot 2", int'(look_line), 2);
        do_flush(2);
        check("R6 mask slot 2", int'(release_mask), 8'h04);
        do_look(20);
        check("R4 falls to slot 5", int'(look_line), 6);
        check("R5 filled line ready", int'(look_ready), 1);
        do_look(33);
        check("R5 miss ready low", int'(look_ready), 0);
        check("R5 miss line 0", int'(look_line), 0);
        do_flush(0);
        check("R6 empty flush mask zero", int'(release_mask), 0);
        clear_all();
    endtask

    task automatic t_shared();
        do_bind(3, 31, 2);
        do_bind(4, 32, 1);
        do_bind(5, 33, 0);
        do_fill(4);
        for (int r = 31; r <= 33; r++) begin
            do_look(r);
            check("R8 shared line", int'(look_line), 4);
            check("R8 shared ready", int'(look_ready), 1);
        end
        do_flush(4);
        check("R8 three slots released", int'(release_mask), 8'h38);
        do_look(32);
        check("R6 slot unbound after flush", int'(look_hit), 0);
        check("R6 mask clears next cycle", int'(release_mask), 0);
        do_bind(4, 32, 1);
        do_look(32);
        check("R6 flushed line not ready", int'(look_ready), 0);
        clear_all();
    endtask

    task automatic t_preload_collide();
        do_bind(1, 12, 1);
        do_bind(1, 0, 0);
        check("R7 preload no err", int'(bind_err), 0);
        do_look(12);
        check("R7 slot unchanged hit", int'(look_hit), 1);
        check("R7 slot unchanged line", int'(look_line), 1);
        do_look(0);
        check("R7 reg 0 misses", int'(look_hit), 0);
        do_fill(1);
        do_look(12);
        check("R9 ready before collision", int'(look_ready), 1);
        cyc(0, 0, 0, 0, 0, 0, 1, 1, 1, 1);
        do_bind(1, 12, 1);
        do_look(12);
        check("R9 flush beats fill", int'(look_ready), 0);
        clear_all();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mapping();
        t_illegal();
        t_priority_ready();
        t_shared();
        t_preload_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule